// File: doc/BRIEF.md
# Selectable-Policy Direct-Mapped Cache Controller

This block is a direct-mapped data cache that sits between a CPU request port and a slower main-memory port. The CPU port moves 64-bit words and takes a word address, a write strobe, write data and a per-byte write mask. The memory port moves whole lines as bursts of one word per beat, and also single masked words. Each line holds a valid bit, a dirty bit and a tag. Every request is looked up against the line that its index selects, and a miss is handled by a small state machine before the CPU is answered.

The `WRITE_BACK` parameter picks the write policy. When it is 1, write hits stay in the cache and mark the line dirty. A write miss first loads the line. A dirty line goes out to memory as a burst before its slot is refilled. When it is 0, every write goes to memory as a single masked word. A write hit also updates the line. A write miss leaves the cache alone, so lines are never dirty.

With the default parameters a byte address splits as follows. Bits [4:0] are the offset within a 32-byte line, and bits [4:3] select one of four words. Bits [8:5] are the line index, for 16 lines. The bits above bit 8 are the tag. The CPU address port carries bits [31:3] of the byte address. Memory commands carry full byte addresses.

Top module: `wpc_cache`

## Requirements
- R1: Once reset is released, `cpu_req_ready_o` is high and neither `cpu_rsp_valid_o` nor `mem_cmd_valid_o` is asserted. Every line is invalid, so the first access to any line issues a line refill.
- R2: A read miss issues one burst read command (`mem_cmd_we_o`=0, `mem_cmd_burst_o`=1) for the line. The returned beats fill the line in ascending word order. The requested word is then returned.
- R3: A read hit returns the stored word and issues no memory command.
- R4: In write-back mode a write hit issues no memory command and leaves the memory word unchanged. The line becomes dirty.
- R5: In write-back mode a miss on a valid dirty line first burst-writes the whole old line to the address given by its stored tag. Memory then holds the modified bytes, and the refill follows. A clean line is replaced with no write.
- R6: In write-back mode a write miss refills the line and then applies the write as a hit. No single-word memory write is issued.
- R7: In write-through mode a write hit updates the line and issues exactly one single-word memory write (`mem_cmd_burst_o`=0) carrying the request's byte mask. No burst write is ever issued.
- R8: In write-through mode a write miss issues one single-word memory write and leaves the cache unchanged, so a later read of that address misses.
- R9: Bit b of the byte mask selects byte b (bits 8b+7..8b) of the 64-bit word. Unselected bytes keep their values. Reads return the full word.
- R10: `cpu_req_ready_o` is high only while no request is in flight. It drops after acceptance and stays low until the single one-cycle `cpu_rsp_valid_o` pulse for that request.
- R11: A memory command keeps its address and type until `mem_cmd_ready_i`. Burst addresses are aligned to the line, and single-word addresses are aligned to the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_valid_i | input | 1 | CPU request valid |
| cpu_req_ready_o | output | 1 | Controller can accept a request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W-3 | Word address (byte address bits [31:3]) |
| cpu_wdata_i | input | 8*WORD_BYTES | Write data |
| cpu_be_i | input | WORD_BYTES | Byte write mask |
| cpu_rsp_valid_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 8*WORD_BYTES | Read data, valid with the pulse for reads |
| mem_cmd_valid_o | output | 1 | Memory command valid |
| mem_cmd_ready_i | input | 1 | Memory command accepted |
| mem_cmd_we_o | output | 1 | Command is a write |
| mem_cmd_burst_o | output | 1 | 1 = whole line, 0 = single word |
| mem_cmd_addr_o | output | ADDR_W | Byte address of the command |
| mem_wvalid_o | output | 1 | Write beat valid |
| mem_wready_i | input | 1 | Write beat accepted |
| mem_wdata_o | output | 8*WORD_BYTES | Write beat data |
| mem_wbe_o | output | WORD_BYTES | Write beat byte mask |
| mem_rvalid_i | input | 1 | Read beat valid |
| mem_rdata_i | input | 8*WORD_BYTES | Read beat data |

## Verification
The bench aims at a miss on a dirty line. A controller that skipped the eviction or wrote back under the new tag would leave stale bytes in memory, and one that evicted clean lines would show an extra burst write. It also covers write misses under both policies. A write-through miss that allocated would make the next read hit with no refill, and a write-back miss that wrote straight to memory would show a single-word write. Partial byte masks on hits and after refills expose a design that merges the wrong lanes. A controller that raised ready during a refill would be caught by the handshake check made on every access.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_WB_CMD, S_WB_DATA,
    S_FILL_CMD, S_FILL_DATA, S_WT_CMD, S_WT_DATA
  } wpc_state_e;
endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INDEX_W-1:0] idx_i,
  input  logic               fill_i,
  input  logic               mark_dirty_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic               valid_o,
  output logic               dirty_o,
  output logic [TAG_W-1:0]   tag_o
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
  parameter int AW         = 6,
  parameter int WORD_BYTES = 8
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [8*WORD_BYTES-1:0] wdata_i,
  input  logic [WORD_BYTES-1:0]   be_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [8*WORD_BYTES-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  // one narrow array per byte lane keeps masked writes free of read-modify-write
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[b]) lane_q[waddr_i] <= wdata_i[8*b +: 8];
    end
    assign rdata_o[8*b +: 8] = lane_q[raddr_i];
  end
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
  import wpc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INDEX_W    = 4,
  parameter int OFFSET_W   = 5,
  parameter int WORD_BYTES = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cpu_req_valid_i,
  output logic                           cpu_req_ready_o,
  input  logic                           cpu_we_i,
  input  logic [ADDR_W-$clog2(WORD_BYTES)-1:0] cpu_addr_i,
  input  logic [8*WORD_BYTES-1:0]        cpu_wdata_i,
  input  logic [WORD_BYTES-1:0]          cpu_be_i,
  output logic                           cpu_rsp_valid_o,
  output logic [8*WORD_BYTES-1:0]        cpu_rdata_o,
  output logic                           mem_cmd_valid_o,
  input  logic                           mem_cmd_ready_i,
  output logic                           mem_cmd_we_o,
  output logic                           mem_cmd_burst_o,
  output logic [ADDR_W-1:0]              mem_cmd_addr_o,
  output logic                           mem_wvalid_o,
  input  logic                           mem_wready_i,
  output logic [8*WORD_BYTES-1:0]        mem_wdata_o,
  output logic [WORD_BYTES-1:0]          mem_wbe_o,
  input  logic                           mem_rvalid_i,
  input  logic [8*WORD_BYTES-1:0]        mem_rdata_i
);
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int WSEL_W = $clog2(WORD_BYTES);
  localparam int WIDX_W = OFFSET_W - WSEL_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - OFFSET_W;
  localparam int RA_W   = ADDR_W - WSEL_W;
  localparam int DA_W   = INDEX_W + WIDX_W;

  wpc_state_e state_q, state_d;
  logic [RA_W-1:0]       req_addr_q;
  logic                  we_q;
  logic [WORD_W-1:0]     wdata_q;
  logic [WORD_BYTES-1:0] be_q;
  logic [WIDX_W-1:0]     beat_q;

  logic [TAG_W-1:0]   req_tag, line_tag;
  logic [INDEX_W-1:0] req_idx;
  logic [WIDX_W-1:0]  req_widx;
  logic line_valid, line_dirty, hit, last_beat;

  logic                  ds_we;
  logic [DA_W-1:0]       ds_waddr, ds_raddr;
  logic [WORD_W-1:0]     ds_wdata, ds_rdata;
  logic [WORD_BYTES-1:0] ds_be;
  logic                  ts_fill, ts_dirty;

  assign req_tag   = req_addr_q[RA_W-1 -: TAG_W];
  assign req_idx   = req_addr_q[WIDX_W +: INDEX_W];
  assign req_widx  = req_addr_q[WIDX_W-1:0];
  assign hit       = line_valid && (line_tag == req_tag);
  assign last_beat = &beat_q;

  wpc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .idx_i(req_idx), .fill_i(ts_fill), .mark_dirty_i(ts_dirty), .tag_i(req_tag),
    .valid_o(line_valid), .dirty_o(line_dirty), .tag_o(line_tag)
  );

  wpc_data_store #(.AW(DA_W), .WORD_BYTES(WORD_BYTES)) u_data (
    .clk_i,
    .we_i(ds_we), .waddr_i(ds_waddr), .wdata_i(ds_wdata), .be_i(ds_be),
    .raddr_i(ds_raddr), .rdata_o(ds_rdata)
  );

  assign cpu_rdata_o = ds_rdata;
  assign mem_wdata_o = (state_q == S_WT_DATA) ? wdata_q : ds_rdata;

  always_comb begin
    state_d         = state_q;
    cpu_req_ready_o = (state_q == S_IDLE);
    cpu_rsp_valid_o = 1'b0;
    mem_cmd_valid_o = 1'b0;
    mem_cmd_we_o    = 1'b0;
    mem_cmd_burst_o = 1'b1;
    mem_cmd_addr_o  = {req_tag, req_idx, {OFFSET_W{1'b0}}};
    mem_wvalid_o    = 1'b0;
    mem_wbe_o       = '1;
    ds_we           = 1'b0;
    ds_waddr        = {req_idx, req_widx};
    ds_raddr        = {req_idx, req_widx};
    ds_wdata        = wdata_q;
    ds_be           = be_q;
    ts_fill         = 1'b0;
    ts_dirty        = 1'b0;
    unique case (state_q)
      S_IDLE: if (cpu_req_valid_i) state_d = S_LOOKUP;
      S_LOOKUP: begin
        if (hit) begin
          if (!we_q) begin
            cpu_rsp_valid_o = 1'b1;
            state_d         = S_IDLE;
          end else begin
            ds_we = 1'b1;
            if (WRITE_BACK) begin
              ts_dirty        = 1'b1;
              cpu_rsp_valid_o = 1'b1;
              state_d         = S_IDLE;
            end else begin
              state_d = S_WT_CMD;
            end
          end
        end else if (we_q && !WRITE_BACK) begin
          state_d = S_WT_CMD;
        end else if (line_valid && line_dirty) begin
          state_d = S_WB_CMD;
        end else begin
          state_d = S_FILL_CMD;
        end
      end
      S_WB_CMD: begin
        mem_cmd_valid_o = 1'b1;
        mem_cmd_we_o    = 1'b1;
        mem_cmd_addr_o  = {line_tag, req_idx, {OFFSET_W{1'b0}}};
        if (mem_cmd_ready_i) state_d = S_WB_DATA;
      end
      S_WB_DATA: begin
        mem_wvalid_o = 1'b1;
        ds_raddr     = {req_idx, beat_q};
        if (mem_wready_i && last_beat) state_d = S_FILL_CMD;
      end
      S_FILL_CMD: begin
        mem_cmd_valid_o = 1'b1;
        if (mem_cmd_ready_i) state_d = S_FILL_DATA;
      end
      S_FILL_DATA: begin
        if (mem_rvalid_i) begin
          ds_we    = 1'b1;
          ds_waddr = {req_idx, beat_q};
          ds_wdata = mem_rdata_i;
          ds_be    = '1;
          if (last_beat) begin
            ts_fill = 1'b1;
            state_d = S_LOOKUP;  // replay: the request now hits
          end
        end
      end
      S_WT_CMD: begin
        mem_cmd_valid_o = 1'b1;
        mem_cmd_we_o    = 1'b1;
        mem_cmd_burst_o = 1'b0;
        mem_cmd_addr_o  = {req_addr_q, {WSEL_W{1'b0}}};
        if (mem_cmd_ready_i) state_d = S_WT_DATA;
      end
      S_WT_DATA: begin
        mem_wvalid_o = 1'b1;
        mem_wbe_o    = be_q;
        if (mem_wready_i) begin
          cpu_rsp_valid_o = 1'b1;
          state_d         = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      req_addr_q <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
      be_q       <= '0;
      beat_q     <= '0;
    end else begin
      state_q <= state_d;
      if (cpu_req_valid_i && cpu_req_ready_o) begin
        req_addr_q <= cpu_addr_i;
        we_q       <= cpu_we_i;
        wdata_q    <= cpu_wdata_i;
        be_q       <= cpu_be_i;
      end
      if (mem_cmd_valid_o && mem_cmd_ready_i) beat_q <= '0;
      else if ((mem_wvalid_o && mem_wready_i) || (state_q == S_FILL_DATA && mem_rvalid_i))
        beat_q <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/wpc_cache_chk.sv
module wpc_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int OFFSET_W   = 5,
  parameter int WORD_BYTES = 8,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_valid_i,
  input logic              cpu_req_ready_o,
  input logic              cpu_rsp_valid_o,
  input logic              mem_cmd_valid_o,
  input logic              mem_cmd_ready_i,
  input logic              mem_cmd_we_o,
  input logic              mem_cmd_burst_o,
  input logic [ADDR_W-1:0] mem_cmd_addr_o,
  input logic              mem_wvalid_o
);
  localparam int WSEL_W = $clog2(WORD_BYTES);

  logic open_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else if (cpu_req_valid_i && cpu_req_ready_o) open_q <= 1'b1;
    else if (cpu_rsp_valid_o) open_q <= 1'b0;
  end

  assert_single_outstanding_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q |-> !cpu_req_ready_o);
  assert_rsp_has_request_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rsp_valid_o |-> open_q);
  assert_idle_mem_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_ready_o |-> (!mem_cmd_valid_o && !mem_wvalid_o));
  assert_cmd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_valid_o && !mem_cmd_ready_i) |=>
      (mem_cmd_valid_o && $stable(mem_cmd_addr_o) && $stable(mem_cmd_we_o) && $stable(mem_cmd_burst_o)));
  assert_line_aligned_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_valid_o && mem_cmd_burst_o) |-> (mem_cmd_addr_o[OFFSET_W-1:0] == '0));
  assert_word_aligned_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_valid_o && !mem_cmd_burst_o) |-> (mem_cmd_addr_o[WSEL_W-1:0] == '0));

  if (WRITE_BACK) begin : g_wb
    assert_no_single_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_cmd_valid_o && mem_cmd_we_o) |-> mem_cmd_burst_o);
  end else begin : g_wt
    assert_no_burst_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_cmd_valid_o && mem_cmd_we_o) |-> !mem_cmd_burst_o);
  end
endmodule

bind wpc_cache wpc_cache_chk #(
  .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .WORD_BYTES(WORD_BYTES), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cpu_req_valid_i(cpu_req_valid_i), .cpu_req_ready_o(cpu_req_ready_o),
  .cpu_rsp_valid_o(cpu_rsp_valid_o),
  .mem_cmd_valid_o(mem_cmd_valid_o), .mem_cmd_ready_i(mem_cmd_ready_i),
  .mem_cmd_we_o(mem_cmd_we_o), .mem_cmd_burst_o(mem_cmd_burst_o),
  .mem_cmd_addr_o(mem_cmd_addr_o), .mem_wvalid_o(mem_wvalid_o)
);

// File: tb/wpc_cache_test.sv
module wpc_cache_lane #(
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_bad
);
  typedef struct {
    bit          is_rd;
    logic [63:0] data;
    string       req;
  } item_t;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [28:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_data;
  logic        cmd_valid, cmd_we, cmd_burst, wvalid, wready, rvalid;
  logic [31:0] cmd_addr;
  logic [63:0] wdata, rdata;
  logic [7:0]  wbe;
  logic        cmd_rdy = 1'b0;

  wpc_cache #(.WRITE_BACK(WRITE_BACK)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_valid_i(req_valid), .cpu_req_ready_o(req_ready), .cpu_we_i(req_we),
    .cpu_addr_i(req_addr), .cpu_wdata_i(req_wdata), .cpu_be_i(req_be),
    .cpu_rsp_valid_o(rsp_valid), .cpu_rdata_o(rsp_data),
    .mem_cmd_valid_o(cmd_valid), .mem_cmd_ready_i(cmd_rdy), .mem_cmd_we_o(cmd_we),
    .mem_cmd_burst_o(cmd_burst), .mem_cmd_addr_o(cmd_addr),
    .mem_wvalid_o(wvalid), .mem_wready_i(wready), .mem_wdata_o(wdata), .mem_wbe_o(wbe),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata)
  );

  logic [63:0] mem  [1024];
  logic [63:0] view [1024];
  bit          m_v [16];
  bit          m_d [16];
  int          m_t [16];
  item_t       sb [$];
  item_t       mon_it;
  int          rsp_cnt = 0;
  int          n_brd = 0, n_bwr = 0, n_swr = 0;
  int          mmode = 0, mbase = 0, mk = 0, mlen = 1;
  bit          tog = 1'b0;
  logic [31:0] hold_addr = '0;

  function automatic logic [63:0] seed_word(int i);
    return {32'hC0DE_0000 + 32'(i), 32'h0BAD_F00D ^ 32'(i * 7)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (wb=%0d): actual %h expected %h", req, WRITE_BACK, act, exp);
    end
  endtask

  // memory model: command ready one cycle after valid, beats every other cycle
  assign wready = (mmode == 1) && tog;
  assign rvalid = (mmode == 2) && tog;
  assign rdata  = mem[mbase + mk];

  always @(posedge clk) begin
    tog <= ~tog;
    if (mmode == 0) begin
      if (cmd_valid && !cmd_rdy) hold_addr <= cmd_addr;
      if (cmd_valid && cmd_rdy) begin
        chk("R11", cmd_addr, hold_addr);
        chk("R11", cmd_addr, cmd_burst ? {cmd_addr[31:5], 5'b0} : {cmd_addr[31:3], 3'b0});
        cmd_rdy <= 1'b0;
        mbase   <= int'(cmd_addr[12:3]);
        mk      <= 0;
        mlen    <= cmd_burst ? 4 : 1;
        mmode   <= cmd_we ? 1 : 2;
        if (!cmd_we) n_brd <= n_brd + 1;
        else if (cmd_burst) n_bwr <= n_bwr + 1;
        else n_swr <= n_swr + 1;
      end else begin
        cmd_rdy <= cmd_valid;
      end
    end else if (mmode == 1 && wready && wvalid) begin
      for (int b = 0; b < 8; b++)
        if (wbe[b]) mem[mbase + mk][8*b +: 8] <= wdata[8*b +: 8];
      if (mk == mlen - 1) mmode <= 0;
      mk <= mk + 1;
    end else if (mmode == 2 && rvalid) begin
      if (mk == mlen - 1) mmode <= 0;
      mk <= mk + 1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk("R10", 64'd1, 64'd0);
      end else begin
        mon_it = sb.pop_front();
        if (mon_it.is_rd) chk(mon_it.req, rsp_data, mon_it.data);
      end
      rsp_cnt++;
    end
  end

  task automatic access(input logic [31:0] a, input bit we, input logic [63:0] wd,
                        input logic [7:0] be, input string dreq, input string treq);
    int idx = int'(a[8:5]);
    int tg  = int'(a[31:9]);
    int w   = int'(a[12:3]);
    int eb = 0, ew = 0, es = 0;
    bit hit = m_v[idx] && (m_t[idx] == tg);
    int b0, b1, b2, c0;
    bit early = 1'b0;
    item_t it;
    if (WRITE_BACK) begin
      if (!hit) begin
        if (m_v[idx] && m_d[idx]) ew = 1;
        eb = 1; m_v[idx] = 1'b1; m_t[idx] = tg; m_d[idx] = 1'b0;
      end
      if (we) m_d[idx] = 1'b1;
    end else begin
      if (we) es = 1;
      else if (!hit) begin eb = 1; m_v[idx] = 1'b1; m_t[idx] = tg; end
    end
    it.is_rd = !we; it.data = view[w]; it.req = dreq;
    sb.push_back(it);
    if (we) for (int b = 0; b < 8; b++) if (be[b]) view[w][8*b +: 8] = wd[8*b +: 8];
    b0 = n_brd; b1 = n_bwr; b2 = n_swr; c0 = rsp_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[31:3]; req_we = we; req_wdata = wd; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (rsp_cnt != c0) break;
      if (req_ready) begin early = 1'b1; break; end
      @(negedge clk);
    end
    chk("R10", 64'(early), 64'd0);
    chk(treq, 64'(n_brd - b0), 64'(eb));
    chk(treq, 64'(n_bwr - b1), 64'(ew));
    chk(treq, 64'(n_swr - b2), 64'(es));
  endtask

  localparam logic [31:0] A = 32'h000, B = 32'h200, C = 32'h048, D = 32'h448;

  initial begin
    done = 1'b0; n_chk = 0; n_bad = 0;
    for (int i = 0; i < 1024; i++) begin mem[i] = seed_word(i); view[i] = seed_word(i); end
    for (int i = 0; i < 16; i++) begin m_v[i] = 1'b0; m_d[i] = 1'b0; m_t[i] = 0; end
    wait (rst_n);
    @(negedge clk);
    chk("R1", {61'd0, req_ready, rsp_valid, cmd_valid}, 64'b100);
    if (WRITE_BACK) begin
      access(A, 0, '0, '0, "R2", "R1");
      access(A + 8, 0, '0, '0, "R3", "R3");
      access(A + 8, 1, 64'h1111_2222_3333_4444, 8'h0F, "R4", "R4");
      chk("R4", mem[1], seed_word(1));
      access(A + 8, 0, '0, '0, "R9", "R3");
      access(B, 0, '0, '0, "R2", "R5");
      chk("R5", mem[1], view[1]);
      access(B + 16, 0, '0, '0, "R3", "R3");
      access(A, 0, '0, '0, "R2", "R5");
      access(C, 1, 64'hAAAA_BBBB_CCCC_DDDD, 8'hF0, "R6", "R6");
      chk("R6", mem[9], seed_word(9));
      access(C, 0, '0, '0, "R9", "R6");
      access(D, 1, 64'h0123_4567_89AB_CDEF, 8'h3C, "R6", "R5");
      chk("R5", mem[9], view[9]);
      access(D, 0, '0, '0, "R9", "R3");
    end else begin
      access(A, 0, '0, '0, "R2", "R1");
      access(A + 8, 1, 64'h1111_2222_3333_4444, 8'h0F, "R7", "R7");
      chk("R7", mem[1], view[1]);
      access(A + 8, 0, '0, '0, "R9", "R3");
      access(C, 1, 64'hAAAA_BBBB_CCCC_DDDD, 8'hF0, "R8", "R8");
      chk("R8", mem[9], view[9]);
      access(C, 0, '0, '0, "R8", "R8");
      access(B, 0, '0, '0, "R2", "R7");
      access(B + 24, 1, 64'hFEDC_BA98_7654_3210, 8'h81, "R7", "R7");
      chk("R7", mem[67], view[67]);
      access(B + 24, 0, '0, '0, "R9", "R3");
    end
    done = 1'b1;
  end
endmodule

module wpc_cache_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic done_wb, done_wt;
  int   c_wb, b_wb, c_wt, b_wt;
  int   tot_c, tot_b;

  always #5 clk = ~clk;

  wpc_cache_lane #(.WRITE_BACK(1'b1)) lane_wb (
    .clk(clk), .rst_n(rst_n), .done(done_wb), .n_chk(c_wb), .n_bad(b_wb));
  wpc_cache_lane #(.WRITE_BACK(1'b0)) lane_wt (
    .clk(clk), .rst_n(rst_n), .done(done_wt), .n_chk(c_wt), .n_bad(b_wt));

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 20000 && !(done_wb && done_wt); cyc++) @(negedge clk);
    tot_c = c_wb + c_wt;
    tot_b = b_wb + b_wt;
    if (!(done_wb && done_wt)) begin
      tot_c++; tot_b++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", tot_c, tot_b);
    $finish;
  end
endmodule